// File: doc/BRIEF.md
# Trigger Busy Resolver

The block merges every condition that should stop new triggers into one active-high busy line toward the trigger system. Six conditions count: a level-1 trigger queue whose occupancy has reached a programmable limit, a busy request from software, a trigger receiver that is not ready, a clock PLL that has not locked, any of six front-end channels that reports busy and is not masked off, and a held busy register.

The busy register is set by an explicit request or by expiry of a level-0 watchdog. That watchdog starts on a level-0 trigger and is cancelled by the level-1 decision that follows it. An expiry also leaves a sticky timeout flag. A single clear input drops both the register and the flag, and a set in the same cycle wins over that clear. The queue threshold and an event-ready timeout value are loaded through a small configuration write port. The event-ready value is only held and presented for a downstream sequencer.

Top module: `busy_resolver`

## Requirements
- R1: While reset is held, and on the first cycle after release, `busy_o` is 1, `ch_busy_o` is 0, `l0_timeout_o` is 0 and `evr_timeout_o` is 300.
- R2: When `l1_count_i` is greater than or equal to the queue threshold, `busy_o` is 1 one cycle later. The threshold resets to 7, so a count of 6 alone gives no busy and a count of 7 does.
- R3: A write with `cfg_we_i`=1 and `cfg_sel_i`=0 loads the threshold from `cfg_wdata_i[CNT_W-1:0]`. The new value is used from the following cycle.
- R4: `sw_busy_i`=1 makes `busy_o` 1 one cycle later.
- R5: `rx_ready_i` and `pll_lock_i` each pass through two synchronizing flops. A low level held from a given cycle sets `busy_o` three clock edges later, and not earlier.
- R6: `ch_busy_o` equals `ch_busy_i & ~ch_dis_i`, registered by one cycle. A channel whose disable bit is 1 never makes `busy_o` high.
- R7: In the busy register, `busy_set_i` sets and `busy_clr_i` clears. When both are 1 in the same cycle, set wins. The register reaches `busy_o` one cycle after it changes.
- R8: A level-0 trigger on `l0_i` when the timer is idle starts the timer. If no `l1_i` comes, the timer expires on the 250th clock edge after the start edge. That edge sets `l0_timeout_o` and the busy register.
- R9: `l1_i` while the timer runs stops and clears it, and no expiry follows. `l0_i` while the timer runs has no effect on the expiry time, and `l1_i` while idle has no effect.
- R10: `l0_timeout_o` is sticky. It is cleared by `busy_clr_i`, and an expiry in the same cycle as a clear leaves it set.
- R11: A write with `cfg_sel_i`=1 loads `evr_timeout_o` from `cfg_wdata_i`, visible one cycle later.
- R12: `busy_o` is the registered OR of all sources above and is active high. It is 0 only when every source is quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l1_count_i | input | CNT_W | Triggers held in the level-1 queue |
| sw_busy_i | input | 1 | Busy forced by software |
| busy_set_i | input | 1 | Set the busy register |
| busy_clr_i | input | 1 | Clear busy register and timeout flag |
| rx_ready_i | input | 1 | Trigger receiver ready, asynchronous |
| pll_lock_i | input | 1 | Clock PLL locked, asynchronous |
| ch_busy_i | input | N_CH | Per-channel busy |
| ch_dis_i | input | N_CH | Per-channel disable mask |
| l0_i | input | 1 | Level-0 trigger strobe |
| l1_i | input | 1 | Level-1 decision strobe |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 1 | 0 selects threshold, 1 selects event-ready timeout |
| cfg_wdata_i | input | EVR_W | Configuration write data |
| busy_o | output | 1 | Merged busy, active high |
| ch_busy_o | output | N_CH | Masked per-channel busy |
| l0_timeout_o | output | 1 | Sticky level-0 timeout flag |
| evr_timeout_o | output | EVR_W | Event-ready timeout value |

## Verification
Two things can land on the same clock edge: a watchdog expiry and a clear of the busy register and timeout flag. Explicit set and clear requests can also coincide. The bench provokes both on purpose. It counts a level-0 start forward so that `busy_clr_i` is high exactly on the expiry edge, and it raises set and clear together. It then expects the flag and `busy_o` to stay high, and only a later lone clear may drop them. The random phase applies the same rule on every cycle where the cycle model sees such a collision.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic {
    CFG_THR = 1'b0,
    CFG_EVR = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/bsr_sync.sv
module bsr_sync #(
  parameter int W       = 1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL;
        s2_q <= RST_VAL;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
      end
    end
    assign q_o[g] = s2_q;
  end
endmodule

// File: rtl/bsr_flag.sv
module bsr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;  // set has priority
    else if (clr_i) q_o <= 1'b0;
  end

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  p_clr_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/bsr_l0_timer.sv
module bsr_l0_timer #(
  parameter int L0_TO = 250,
  localparam int TMR_W = $clog2(L0_TO)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic l0_i,
  input  logic l1_i,
  output logic expire_o
);
  logic             run_q;
  logic [TMR_W-1:0] tmr_q;

  assign expire_o = run_q && (tmr_q == TMR_W'(L0_TO - 1)) && !l1_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      tmr_q <= '0;
    end else if (run_q) begin
      if (l1_i || expire_o) begin
        run_q <= 1'b0;
        tmr_q <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end else if (l0_i) begin
      run_q <= 1'b1;
      tmr_q <= '0;
    end
  end

  p_l1_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && l1_i) |=> (!run_q && !expire_o));
  p_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && l0_i) |=> (run_q && tmr_q == '0));
  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !l0_i) |=> !run_q);
endmodule

// File: rtl/busy_resolver.sv
module busy_resolver
  import bsr_pkg::*;
#(
  parameter int N_CH    = 6,
  parameter int CNT_W   = 6,
  parameter int THR_RST = 7,
  parameter int L0_TO   = 250,
  parameter int EVR_W   = 16,
  parameter int EVR_RST = 300
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] l1_count_i,
  input  logic             sw_busy_i,
  input  logic             busy_set_i,
  input  logic             busy_clr_i,
  input  logic             rx_ready_i,
  input  logic             pll_lock_i,
  input  logic [N_CH-1:0]  ch_busy_i,
  input  logic [N_CH-1:0]  ch_dis_i,
  input  logic             l0_i,
  input  logic             l1_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [EVR_W-1:0] cfg_wdata_i,
  output logic             busy_o,
  output logic [N_CH-1:0]  ch_busy_o,
  output logic             l0_timeout_o,
  output logic [EVR_W-1:0] evr_timeout_o
);
  logic [1:0]       link_s;
  logic             rx_ok, pll_ok;
  logic             l0_expire, busy_q;
  logic [CNT_W-1:0] thr_q;
  logic [N_CH-1:0]  ch_masked;
  logic             queue_full, busy_d;

  // Unsynced start value 0 keeps busy high until both links are seen good
  bsr_sync #(.W(2), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pll_lock_i, rx_ready_i}),
    .q_o   (link_s)
  );
  assign rx_ok  = link_s[0];
  assign pll_ok = link_s[1];

  bsr_l0_timer #(.L0_TO(L0_TO)) u_l0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .l0_i    (l0_i),
    .l1_i    (l1_i),
    .expire_o(l0_expire)
  );

  bsr_flag u_busy_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (busy_set_i || l0_expire),
    .clr_i (busy_clr_i),
    .q_o   (busy_q)
  );

  bsr_flag u_to_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (l0_expire),
    .clr_i (busy_clr_i),
    .q_o   (l0_timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q         <= CNT_W'(THR_RST);
      evr_timeout_o <= EVR_W'(EVR_RST);
    end else if (cfg_we_i) begin
      if (cfg_sel_e'(cfg_sel_i) == CFG_THR) thr_q <= cfg_wdata_i[CNT_W-1:0];
      else                                  evr_timeout_o <= cfg_wdata_i;
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign ch_masked[c] = ch_busy_i[c] && !ch_dis_i[c];
  end

  assign queue_full = (l1_count_i >= thr_q);
  assign busy_d = busy_q || sw_busy_i || queue_full || !rx_ok || !pll_ok || (|ch_masked);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o    <= 1'b1;
      ch_busy_o <= '0;
    end else begin
      busy_o    <= busy_d;
      ch_busy_o <= ch_masked;
    end
  end

  p_queue_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l1_count_i >= thr_q) |=> busy_o);
  p_sw_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_busy_i |=> busy_o);
  p_link_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_ok || !pll_ok) |=> busy_o);
  p_mask_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ch_busy_o & $past(ch_dis_i)) == '0));
  p_expire_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l0_expire |=> (l0_timeout_o && busy_q));
  p_evr_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i) |=> (evr_timeout_o == $past(cfg_wdata_i)));
  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !sw_busy_i && !queue_full && rx_ok && pll_ok && ch_masked == '0) |=> !busy_o);
endmodule

// File: tb/tb_busy_resolver.sv
module tb_busy_resolver;
  localparam int N_CH = 6, CNT_W = 6, EVR_W = 16, L0_TO = 250;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #10 clk_i = ~clk_i;  // 50 MHz

  logic [CNT_W-1:0] l1_count_i = '0;
  logic sw_busy_i = 0, busy_set_i = 0, busy_clr_i = 0, rx_ready_i = 0, pll_lock_i = 0;
  logic [N_CH-1:0] ch_busy_i = '0, ch_dis_i = '0;
  logic l0_i = 0, l1_i = 0, cfg_we_i = 0, cfg_sel_i = 0;
  logic [EVR_W-1:0] cfg_wdata_i = '0;
  logic busy_o, l0_timeout_o;
  logic [N_CH-1:0] ch_busy_o;
  logic [EVR_W-1:0] evr_timeout_o;

  busy_resolver dut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // cycle model
  bit m_rx1, m_rx2, m_pl1, m_pl2, m_bq, m_st, m_run, m_busy;
  int m_tmr, m_thr, m_evr;
  logic [N_CH-1:0] m_chb;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_busy_next();
    return m_bq || sw_busy_i || (int'(l1_count_i) >= m_thr) || !m_rx2 || !m_pl2 ||
           ((ch_busy_i & ~ch_dis_i) != '0);
  endfunction

  task automatic step();
    bit b_n, expire;
    @(posedge clk_i);
    b_n    = exp_busy_next();
    expire = m_run && (m_tmr == L0_TO - 1) && !l1_i;
    m_chb  = ch_busy_i & ~ch_dis_i;
    m_busy = b_n;
    if (m_run) begin
      if (l1_i || expire) begin m_run = 0; m_tmr = 0; end
      else m_tmr++;
    end else if (l0_i) begin m_run = 1; m_tmr = 0; end
    if (busy_set_i || expire) m_bq = 1; else if (busy_clr_i) m_bq = 0;
    if (expire) m_st = 1; else if (busy_clr_i) m_st = 0;
    if (cfg_we_i) begin
      if (!cfg_sel_i) m_thr = int'(cfg_wdata_i[CNT_W-1:0]);
      else m_evr = int'(cfg_wdata_i);
    end
    m_rx2 = m_rx1; m_rx1 = rx_ready_i;
    m_pl2 = m_pl1; m_pl1 = pll_lock_i;
    @(negedge clk_i);
    chk("R12 model busy", int'(busy_o), int'(m_busy));
    chk("R6 model ch_busy", int'(ch_busy_o), int'(m_chb));
    chk("R8 model timeout", int'(l0_timeout_o), int'(m_st));
    chk("R11 model evr", int'(evr_timeout_o), m_evr);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic quiet();
    l1_count_i = '0; sw_busy_i = 0; busy_set_i = 0; busy_clr_i = 0;
    rx_ready_i = 1; pll_lock_i = 1; ch_busy_i = '0; ch_dis_i = '0;
    l0_i = 0; l1_i = 0; cfg_we_i = 0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_rx1 = 0; m_rx2 = 0; m_pl1 = 0; m_pl2 = 0; m_bq = 0; m_st = 0; m_run = 0;
    m_busy = 1; m_tmr = 0; m_thr = 7; m_evr = 300; m_chb = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy in reset", int'(busy_o), 1);
    chk("R1 ch_busy in reset", int'(ch_busy_o), 0);
    chk("R1 timeout in reset", int'(l0_timeout_o), 0);
    chk("R1 evr reset 300", int'(evr_timeout_o), 300);
    rst_ni = 1;
    quiet();
    step();
    chk("R1 busy first cycle", int'(busy_o), 1);
    steps(3);
    chk("R12 idle busy low", int'(busy_o), 0);
    // R2 threshold reset value
    l1_count_i = 6; steps(2);
    chk("R2 count 6 below 7", int'(busy_o), 0);
    l1_count_i = 7; step();
    chk("R2 count 7 busy", int'(busy_o), 1);
    // R3 threshold write
    l1_count_i = 3; cfg_we_i = 1; cfg_sel_i = 0; cfg_wdata_i = 16'd4; step();
    cfg_we_i = 0; step();
    chk("R3 count 3 thr 4", int'(busy_o), 0);
    l1_count_i = 4; step();
    chk("R3 count 4 thr 4", int'(busy_o), 1);
    l1_count_i = 0; step();
    // R4
    sw_busy_i = 1; step();
    chk("R4 sw busy", int'(busy_o), 1);
    sw_busy_i = 0; step();
    chk("R4 sw release", int'(busy_o), 0);
    // R5 sync latency
    rx_ready_i = 0; steps(2);
    chk("R5 rx not yet", int'(busy_o), 0);
    step();
    chk("R5 rx busy", int'(busy_o), 1);
    rx_ready_i = 1; steps(3);
    chk("R5 rx recover", int'(busy_o), 0);
    pll_lock_i = 0; steps(2);
    chk("R5 pll not yet", int'(busy_o), 0);
    step();
    chk("R5 pll busy", int'(busy_o), 1);
    pll_lock_i = 1; steps(3);
    // R6 mask
    ch_busy_i = 6'b100101; ch_dis_i = 6'b100101; step();
    chk("R6 disabled busy", int'(busy_o), 0);
    chk("R6 disabled status", int'(ch_busy_o), 0);
    ch_dis_i = 6'b000100; step();
    chk("R6 enabled busy", int'(busy_o), 1);
    chk("R6 enabled status", int'(ch_busy_o), 6'b100001);
    ch_busy_i = '0; ch_dis_i = '0; step();
    // R7 set/clear
    busy_set_i = 1; step(); busy_set_i = 0; step();
    chk("R7 set", int'(busy_o), 1);
    busy_set_i = 1; busy_clr_i = 1; step(); busy_set_i = 0; busy_clr_i = 0; step();
    chk("R7 set wins", int'(busy_o), 1);
    busy_clr_i = 1; step(); busy_clr_i = 0; step();
    chk("R7 clear", int'(busy_o), 0);
    // R8 expiry
    l0_i = 1; step(); l0_i = 0; steps(L0_TO - 1);
    chk("R8 before expiry", int'(l0_timeout_o), 0);
    step();
    chk("R8 expiry flag", int'(l0_timeout_o), 1);
    step();
    chk("R8 expiry busy", int'(busy_o), 1);
    busy_clr_i = 1; step(); busy_clr_i = 0;
    chk("R10 flag cleared", int'(l0_timeout_o), 0);
    step();
    // R10 expiry and clear same edge
    l0_i = 1; step(); l0_i = 0; steps(L0_TO - 1);
    busy_clr_i = 1; step(); busy_clr_i = 0;
    chk("R10 expiry beats clear", int'(l0_timeout_o), 1);
    step();
    chk("R10 busy kept", int'(busy_o), 1);
    busy_clr_i = 1; step(); busy_clr_i = 0; step();
    chk("R10 lone clear", int'(l0_timeout_o), 0);
    // R9 l1 cancels
    l0_i = 1; step(); l0_i = 0; steps(100);
    l1_i = 1; step(); l1_i = 0; steps(300);
    chk("R9 l1 cancels", int'(l0_timeout_o), 0);
    chk("R9 no busy", int'(busy_o), 0);
    // R9 second l0 ignored
    l0_i = 1; step(); l0_i = 0; steps(100);
    l0_i = 1; step(); l0_i = 0; steps(L0_TO - 102);
    chk("R9 restart ignored pre", int'(l0_timeout_o), 0);
    step();
    chk("R9 restart ignored exp", int'(l0_timeout_o), 1);
    busy_clr_i = 1; step(); busy_clr_i = 0; step();
    // R11
    cfg_we_i = 1; cfg_sel_i = 1; cfg_wdata_i = 16'd1234; step(); cfg_we_i = 0;
    chk("R11 evr write", int'(evr_timeout_o), 1234);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      l1_count_i  = CNT_W'($urandom % 10);
      sw_busy_i   = ($urandom % 8) == 0;
      busy_set_i  = ($urandom % 16) == 0;
      busy_clr_i  = ($urandom % 6) == 0;
      rx_ready_i  = ($urandom % 8) != 0;
      pll_lock_i  = ($urandom % 8) != 0;
      ch_busy_i   = N_CH'($urandom);
      ch_dis_i    = N_CH'($urandom);
      l0_i        = ($urandom % 24) == 0;
      l1_i        = ($urandom % 320) == 0;
      cfg_we_i    = ($urandom % 40) == 0;
      cfg_sel_i   = 1'($urandom);
      cfg_wdata_i = EVR_W'($urandom % 12);
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule